// File: doc/BRIEF.md
# Serial Clock Pulse-Width Reset Detector

This block watches the serial clock pin of a converter from the system clock domain. It issues a full device reset when a particular timed pattern appears on that pin. The pattern is three high pulses, each longer than the one before, separated by short low gaps. A host that has lost track of the serial state, for example after a brown-out, can use this pattern to restart the device without a dedicated reset pin. The downstream register file uses the reset to return every register to its default value, and the default operating mode is sleep.

The pin is first brought into the system clock domain through a synchronizer chain. A single interval counter then measures how many system clock cycles each high and each low stretch lasts, and the counter saturates instead of wrapping. A small sequencer compares each finished interval against the window for the current step. It emits a one-cycle reset strobe when the falling edge that ends the third pulse arrives and that pulse is in its window.

The block has no data stream, so it has no valid/ready handshake. All pins are plain level signals, and the reset output is a bare one-cycle strobe with no back-pressure.

Top module: `sclk_reset_detect`

## Requirements
- R1: While `rst_ni` is low and in the cycles after it is released, `dev_rst_o` is 0 and the detector is idle.
- R2: The detector accepts this sequence: a first high pulse, a low gap, a second high pulse, a low gap and a third high pulse, each inside its window. On that sequence `dev_rst_o` goes high for exactly one cycle. The pulse is visible 3 system clock cycles after the `sclk_i` sample in which the third pulse falls: two of those cycles are the synchronizer and one is the output register.
- R3: The first pulse counts only if it lasts strictly more than 512 and strictly fewer than 800 system clock cycles. A pulse of 513 or 799 cycles is accepted. A pulse of 512 or 800 cycles is not.
- R4: Each low gap counts only if it lasts strictly more than 10 cycles. A gap of 10 cycles abandons the sequence, and a gap of 11 cycles is accepted.
- R5: The second pulse counts only if it lasts strictly more than 1024 and strictly fewer than 1800 cycles.
- R6: The third pulse counts if it lasts at least 2048 and strictly fewer than 2400 cycles. A pulse of 2048 or 2399 cycles fires the reset. A pulse of 2047 or 2400 cycles does not.
- R7: A pulse outside the window of its step returns the detector to idle. The same pulse is then judged again as a possible first pulse, so a valid second and third pulse after it still fire the reset.
- R8: The interval counter saturates at its all-ones value of 8191 with the default widths. A high stretch longer than that, such as 8792 cycles, is never accepted as a first pulse.
- R9: After a reset has fired, the detector is idle. The pulse is never longer than one cycle, and a second and third pulse without a new first pulse do not fire it again.
- R10: Asserting `rst_ni` in the middle of a sequence discards the progress made so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the detector |
| sclk_i | input | 1 | Serial clock pin, asynchronous to `clk_i` |
| dev_rst_o | output | 1 | One-cycle device reset strobe |

## Verification
The only result is `dev_rst_o`. It is due exactly 3 clock cycles after the `sclk_i` sample that carries the final falling edge: two synchronizer flops plus the sequencer's output register. The bench drives `sclk_i` on falling clock edges and records the cycle number of that edge. A monitor, also on falling edges, records how many strobes appear and the cycle of the last one. Each sequence is checked eight cycles after its final fall, both for the number of strobes (zero or one) and, when a strobe is expected, for its cycle being exactly three after the recorded fall.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;

  // Progress through the three-pulse pattern.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GAP1 = 3'd1,
    ST_HI2  = 3'd2,
    ST_GAP2 = 3'd3,
    ST_HI3  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/prd_sync.sv
`timescale 1ns/1ps
module prd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/prd_interval.sv
`timescale 1ns/1ps
// Measures how long the synchronized level has been stable, in clk cycles.
// On a level change, len_o holds the length of the interval that just ended.
module prd_interval #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  output logic             lvl_o,
  output logic             fall_o,
  output logic             rise_o,
  output logic [CNT_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= CNT_ONE;
    end else if (lvl_i != lvl_q) begin
      lvl_q <= lvl_i;
      cnt_q <= CNT_ONE;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign lvl_o  = lvl_q;
  assign fall_o = lvl_q & ~lvl_i;
  assign rise_o = ~lvl_q & lvl_i;
  assign len_o  = cnt_q;

endmodule

// File: rtl/prd_seq.sv
`timescale 1ns/1ps
module prd_seq
  import prd_pkg::*;
#(
  parameter int CNT_W   = 13,
  parameter int P1_LO   = 512,
  parameter int P1_HI   = 800,
  parameter int GAP_MIN = 10,
  parameter int P2_LO   = 1024,
  parameter int P2_HI   = 1800,
  parameter int P3_LO   = 2048,
  parameter int P3_HI   = 2400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] len_i,
  output seq_state_t       state_o,
  output logic             fire_o
);

  localparam logic [CNT_W-1:0] L1_LO = CNT_W'(P1_LO);
  localparam logic [CNT_W-1:0] L1_HI = CNT_W'(P1_HI);
  localparam logic [CNT_W-1:0] L2_LO = CNT_W'(P2_LO);
  localparam logic [CNT_W-1:0] L2_HI = CNT_W'(P2_HI);
  localparam logic [CNT_W-1:0] L3_LO = CNT_W'(P3_LO);
  localparam logic [CNT_W-1:0] L3_HI = CNT_W'(P3_HI);
  localparam logic [CNT_W-1:0] LG    = CNT_W'(GAP_MIN);

  seq_state_t state_q, state_d;
  logic       fire_q, fire_d;
  logic       hit1, hit2, hit3, gap_ok;

  // Window tests on the interval that just ended.
  assign hit1   = (len_i >  L1_LO) && (len_i < L1_HI);
  assign hit2   = (len_i >  L2_LO) && (len_i < L2_HI);
  assign hit3   = (len_i >= L3_LO) && (len_i < L3_HI);
  assign gap_ok = (len_i >  LG);

  // A failed high pulse is judged again as a first pulse.
  always_comb begin
    state_d = state_q;
    fire_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fall_i && hit1) state_d = ST_GAP1;
      ST_GAP1: if (rise_i) state_d = gap_ok ? ST_HI2 : ST_IDLE;
      ST_HI2: begin
        if (fall_i) begin
          if (hit2)      state_d = ST_GAP2;
          else if (hit1) state_d = ST_GAP1;
          else           state_d = ST_IDLE;
        end
      end
      ST_GAP2: if (rise_i) state_d = gap_ok ? ST_HI3 : ST_IDLE;
      ST_HI3: begin
        if (fall_i) begin
          if (hit3) begin
            fire_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (hit1) begin
            state_d = ST_GAP1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire_d;
    end
  end

  assign state_o = state_q;
  assign fire_o  = fire_q;

endmodule

// File: rtl/sclk_reset_detect.sv
`timescale 1ns/1ps
module sclk_reset_detect
  import prd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int P1_LO       = 512,
  parameter int P1_HI       = 800,
  parameter int GAP_MIN     = 10,
  parameter int P2_LO       = 1024,
  parameter int P2_HI       = 1800,
  parameter int P3_LO       = 2048,
  parameter int P3_HI       = 2400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic dev_rst_o
);

  // One spare bit above the longest window so saturation sits well clear of it.
  localparam int CNT_W = $clog2(P3_HI + 1) + 1;

  logic             sclk_s;
  logic             lvl_w;
  logic             fall_w;
  logic             rise_w;
  logic [CNT_W-1:0] len_w;
  seq_state_t       state_w;

  prd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sclk_i),
    .q_o    (sclk_s)
  );

  prd_interval #(.CNT_W(CNT_W)) u_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sclk_s),
    .lvl_o  (lvl_w),
    .fall_o (fall_w),
    .rise_o (rise_w),
    .len_o  (len_w)
  );

  prd_seq #(
    .CNT_W   (CNT_W),
    .P1_LO   (P1_LO),
    .P1_HI   (P1_HI),
    .GAP_MIN (GAP_MIN),
    .P2_LO   (P2_LO),
    .P2_HI   (P2_HI),
    .P3_LO   (P3_LO),
    .P3_HI   (P3_HI)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall_w),
    .rise_i  (rise_w),
    .len_i   (len_w),
    .state_o (state_w),
    .fire_o  (dev_rst_o)
  );

endmodule

// File: rtl/prd_chk.sv
`timescale 1ns/1ps
module prd_chk
  import prd_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dev_rst_o,
  input logic             lvl_w,
  input logic             fall_w,
  input logic [CNT_W-1:0] len_w,
  input seq_state_t       state_w
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (state_w == ST_IDLE) && !dev_rst_o);

  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |=> !dev_rst_o);

  // R2
  fire_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> $past(fall_w));

  // R6
  fire_from_third_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> ($past(state_w) == ST_HI3));

  // R8
  sat_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_w != CNT_W'(1)) |->
      ((32'(len_w) == 32'($past(len_w)) + 1) ||
       ((len_w == CNT_MAX) && ($past(len_w) == CNT_MAX))));

  // R7
  gap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_w == ST_GAP1) || (state_w == ST_GAP2)) |-> !lvl_w);

  // R7
  pulse_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_w == ST_HI2) || (state_w == ST_HI3)) |-> lvl_w);

endmodule

bind sclk_reset_detect prd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dev_rst_o (dev_rst_o),
  .lvl_w     (lvl_w),
  .fall_w    (fall_w),
  .len_w     (len_w),
  .state_w   (state_w)
);

// File: tb/tb_sclk_reset_detect.sv
`timescale 1ns/1ps
module tb_sclk_reset_detect;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0;
  logic dev_rst_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int pulses = 0;
  int last_cyc = -1;
  bit done = 1'b0;

  sclk_reset_detect dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .dev_rst_o (dev_rst_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni && dev_rst_o) begin
      pulses   = pulses + 1;
      last_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit win1(input int h); return (h > 512) && (h < 800); endfunction
  function automatic bit win2(input int h); return (h > 1024) && (h < 1800); endfunction
  function automatic bit win3(input int h); return (h >= 2048) && (h < 2400); endfunction
  function automatic bit gapok(input int g); return g > 10; endfunction

  function automatic bit expect_fire(input int h1, input int g1, input int h2,
                                     input int g2, input int h3);
    return win1(h1) && gapok(g1) && win2(h2) && gapok(g2) && win3(h3);
  endfunction

  task automatic send_pulse(input int hi, input int lo);
    sclk_i = 1'b1;
    repeat (hi) @(negedge clk);
    sclk_i = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic run_seq(input int h1, input int g1, input int h2, input int g2,
                         input int h3, input bit exp, input string tag);
    int p0;
    int fc;
    p0 = pulses;
    send_pulse(h1, g1);
    send_pulse(h2, g2);
    sclk_i = 1'b1;
    repeat (h3) @(negedge clk);
    sclk_i = 1'b0;
    fc = cyc;
    repeat (8) @(negedge clk);
    check((pulses - p0) == int'(exp), tag, pulses - p0, int'(exp));
    if (exp)
      check(last_cyc == fc + 3, {tag, " R2 latency"}, last_cyc - fc, 3);
    repeat (22) @(negedge clk);
  endtask

  initial begin
    int unsigned seed;
    int p0;
    seed = $urandom(32'd20250611);
    repeat (4) @(negedge clk);
    // R1: strobe low while in reset
    check(dev_rst_o == 1'b0, "R1 in reset", int'(dev_rst_o), 0);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk);
    check(dev_rst_o == 1'b0 && pulses == 0, "R1 after release", pulses, 0);

    // R2: nominal sequences
    run_seq(600, 20, 1400, 20, 2200, 1'b1, "R2 nominal");
    run_seq(700, 40, 1100, 15, 2300, 1'b1, "R2 varied");
    // R3: first pulse bounds
    run_seq(512, 20, 1400, 20, 2200, 1'b0, "R3 h1=512");
    run_seq(800, 20, 1400, 20, 2200, 1'b0, "R3 h1=800");
    run_seq(513, 20, 1400, 20, 2200, 1'b1, "R3 h1=513");
    run_seq(799, 20, 1400, 20, 2200, 1'b1, "R3 h1=799");
    // R4: gap bounds
    run_seq(600, 10, 1400, 20, 2200, 1'b0, "R4 g1=10");
    run_seq(600, 20, 1400, 10, 2200, 1'b0, "R4 g2=10");
    run_seq(600, 11, 1400, 11, 2200, 1'b1, "R4 gaps=11");
    // R5: second pulse bounds
    run_seq(600, 20, 1024, 20, 2200, 1'b0, "R5 h2=1024");
    run_seq(600, 20, 1800, 20, 2200, 1'b0, "R5 h2=1800");
    run_seq(600, 20, 1025, 20, 2200, 1'b1, "R5 h2=1025");
    run_seq(600, 20, 1799, 20, 2200, 1'b1, "R5 h2=1799");
    // R6: third pulse bounds
    run_seq(600, 20, 1400, 20, 2047, 1'b0, "R6 h3=2047");
    run_seq(600, 20, 1400, 20, 2048, 1'b1, "R6 h3=2048");
    run_seq(600, 20, 1400, 20, 2399, 1'b1, "R6 h3=2399");
    run_seq(600, 20, 1400, 20, 2400, 1'b0, "R6 h3=2400");

    // R7: a second pulse that fits only the first window restarts the pattern
    send_pulse(600, 20);
    run_seq(650, 20, 1200, 20, 2200, 1'b1, "R7 restart at step 2");
    // R7: a third pulse that fits only the first window restarts the pattern
    send_pulse(600, 20);
    send_pulse(1200, 20);
    run_seq(700, 20, 1200, 20, 2200, 1'b1, "R7 restart at step 3");

    // R8: overlong first high must saturate, not alias into the first window
    run_seq(8792, 20, 1200, 20, 2200, 1'b0, "R8 saturation");

    // R9: after firing, second and third pulses alone do not fire again
    run_seq(600, 20, 1200, 20, 2200, 1'b1, "R9 fire");
    run_seq(1200, 20, 2200, 20, 2200, 1'b0, "R9 no refire");

    // R10: reset in the middle of a sequence discards progress
    p0 = pulses;
    send_pulse(600, 20);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    send_pulse(1200, 20);
    send_pulse(2200, 30);
    check(pulses == p0, "R10 mid-sequence reset", pulses - p0, 0);

    // Random sequences near the windows (R2 R3 R4 R5 R6)
    for (int k = 0; k < 8; k++) begin
      int h1, g1, h2, g2, h3;
      h1 = int'($urandom_range(810, 500));
      g1 = int'($urandom_range(30, 8));
      h2 = int'($urandom_range(1810, 1015));
      g2 = int'($urandom_range(30, 8));
      h3 = int'($urandom_range(2410, 2040));
      run_seq(h1, g1, h2, g2, h3, expect_fire(h1, g1, h2, g2, h3), "R2 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule